// File: doc/BRIEF.md
# Register Hazard Tracker with Rotating Issue Tags

This block sits in the issue stage of an in-order pipeline. It decides whether the instruction at issue may go ahead this cycle. Each accepted instruction is handed a small tag from a rotating pool. The tag table keeps, for each tag, whether it is outstanding and which register, if any, the instruction will write. A later instruction that reads a register with a pending write stalls. It stays stalled until a writeback carrying the writer's tag arrives. There is no operand forwarding, so a consumer always waits for the register write itself.

Instructions may overlap in flight only while they all target the same execution unit, because that unit keeps them in order. An instruction for another unit is held back until the tag table has drained and the unit busy flag is low. A flush input drops every outstanding tag and pending-write record and returns the tag pointer to zero.

Top module: `hazard_tracker`

## Requirements
- R1: Each accepted instruction receives the tag shown on `iss_tag`. Tags are handed out in rotating order 0,1,2,3,0,... and the pointer advances by one per accept only.
- R2: After reset no tag is outstanding, `iss_tag` is 0 and a request to any unit is accepted when `unit_busy` is 0.
- R3: A request with any valid source (`iss_src_vld[k]`, source k in bits `iss_src[6k+5:6k]`) equal to the destination of an outstanding tag stalls. This applies to every source position and to register 63.
- R4: A writeback (`wb_valid`, `wb_tag`) retires its tag in the same cycle, so a dependent request accepted in that cycle proceeds.
- R5: An instruction issued with `iss_dst_vld` low creates no register hazard, and a source whose valid bit is low never causes a stall.
- R6: Requests to the unit already holding in-flight work are accepted while `unit_busy` is 1 and other tags are outstanding.
- R7: A request for a different unit stalls while any tag is outstanding or `unit_busy` is 1. It is accepted once both are clear.
- R8: When the next tag in rotation is still outstanding, every request stalls. A writeback of a different tag does not release it. A writeback of that very tag in the same cycle does release it.
- R9: While `flush` is high nothing is accepted. In the following cycle no tag or pending write remains and `iss_tag` is 0.
- R10: With `iss_valid` low, `stall` and `iss_accept` are 0. With `iss_valid` high, exactly one of them is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Clear all outstanding tags and pending writes |
| iss_valid | input | 1 | Issue request present |
| iss_src_vld | input | 3 | Per-source valid bits |
| iss_src | input | 18 | Source register numbers, 6 bits each, source 0 lowest |
| iss_dst_vld | input | 1 | Instruction writes a register |
| iss_dst | input | 6 | Destination register number |
| iss_unit | input | 2 | Target execution unit |
| unit_busy | input | 1 | Active unit reports an instruction in progress |
| wb_valid | input | 1 | Writeback this cycle |
| wb_tag | input | 2 | Tag of the instruction being written back |
| stall | output | 1 | Request present but held |
| iss_tag | output | 2 | Tag given to the request if accepted |
| iss_accept | output | 1 | Request accepted this cycle |

## Verification
The hazard check is exercised with pending writers matched through source positions 0, 1 and 2. This separates a comparator error in any single position from a correct match. Invalid sources carrying a pending register number and writers without a destination show whether valid bits gate the comparison. Writebacks of the needed tag, of an unrelated tag, and in the same cycle as the request separate the same-cycle release from a late release or a release on the wrong tag. Unit changes are tried while tags are outstanding, while only the busy flag is high, and after both clear, which separates the drain condition from the busy-flag condition.

// File: rtl/hazard_pkg.sv
// Shared definitions for the register hazard tracker.
// Assumes: consumers import the package; values only order stall causes.
package hazard_pkg;
    typedef enum logic [2:0] {
        HZ_IDLE    = 3'd0,
        HZ_GO      = 3'd1,
        HZ_FLUSH   = 3'd2,
        HZ_TAGFULL = 3'd3,
        HZ_UNIT    = 3'd4,
        HZ_RAW     = 3'd5
    } hz_cause_e;
endpackage

// File: rtl/hazard_tag_table.sv
// Tag table: one entry per tag holding an outstanding bit and the register
// that instruction will write. Allocation follows a rotating pointer.
// Assumes: alloc is only raised when next_free is 1; a writeback retires
// its tag in the same cycle as far as busy_eff is concerned.
module hazard_tag_table #(
    parameter int TAG_W    = 2,
    parameter int REG_W    = 6,
    localparam int NUM_TAGS = 1 << TAG_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      flush,
    input  logic                      alloc,
    input  logic                      alloc_dst_vld,
    input  logic [REG_W-1:0]          alloc_dst,
    input  logic                      wb_vld,
    input  logic [TAG_W-1:0]          wb_tag,
    output logic [TAG_W-1:0]          next_tag,
    output logic                      next_free,
    output logic [NUM_TAGS-1:0]       busy_eff,
    output logic [NUM_TAGS-1:0]       dst_vld,
    output logic [NUM_TAGS*REG_W-1:0] dst_flat
);
    logic [TAG_W-1:0]    ptr_q;
    logic [NUM_TAGS-1:0] busy_q;
    logic [NUM_TAGS-1:0] dvld_q;
    logic [REG_W-1:0]    dst_q [NUM_TAGS];
    logic [NUM_TAGS-1:0] retire;

    for (genvar t = 0; t < NUM_TAGS; t++) begin : g_ent
        assign retire[t] = wb_vld && (wb_tag == TAG_W'(t));
        assign dst_flat[t*REG_W +: REG_W] = dst_q[t];
    end

    assign busy_eff  = busy_q & ~retire;
    assign dst_vld   = dvld_q;
    assign next_tag  = ptr_q;
    assign next_free = !busy_eff[ptr_q];

    // Rotating allocation pointer.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) ptr_q <= '0;
        else if (alloc)      ptr_q <= ptr_q + 1'b1;
    end

    // Entry update: allocation wins over a retire of the same tag.
    always_ff @(posedge clk) begin
        for (int t = 0; t < NUM_TAGS; t++) begin
            if (!rst_n || flush) begin
                busy_q[t] <= 1'b0;
                dvld_q[t] <= 1'b0;
                dst_q[t]  <= '0;
            end else if (alloc && ptr_q == TAG_W'(t)) begin
                busy_q[t] <= 1'b1;
                dvld_q[t] <= alloc_dst_vld;
                dst_q[t]  <= alloc_dst;
            end else if (retire[t]) begin
                busy_q[t] <= 1'b0;
            end
        end
    end

    p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (busy_q == '0));
    p_alloc_marks_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc && !flush) |=> busy_q[$past(ptr_q)]);
    p_ptr_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!alloc && !flush) |=> $stable(ptr_q));
    p_alloc_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> !busy_eff[ptr_q]);
endmodule

// File: rtl/hazard_raw_check.sv
// Read-after-write check: compares every valid source against the
// destination of every outstanding tag that writes a register.
// Assumes: busy_eff already excludes tags retiring this cycle.
module hazard_raw_check #(
    parameter int NUM_SRC  = 3,
    parameter int NUM_TAGS = 4,
    parameter int REG_W    = 6
) (
    input  logic [NUM_SRC-1:0]        src_vld,
    input  logic [NUM_SRC*REG_W-1:0]  src_flat,
    input  logic [NUM_TAGS-1:0]       busy_eff,
    input  logic [NUM_TAGS-1:0]       dst_vld,
    input  logic [NUM_TAGS*REG_W-1:0] dst_flat,
    output logic                      raw_hit
);
    logic [NUM_SRC*NUM_TAGS-1:0] match;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        for (genvar t = 0; t < NUM_TAGS; t++) begin : g_tag
            assign match[s*NUM_TAGS + t] = src_vld[s] && busy_eff[t] && dst_vld[t]
                && (src_flat[s*REG_W +: REG_W] == dst_flat[t*REG_W +: REG_W]);
        end
    end

    assign raw_hit = |match;

    // R5: with no valid source there can be no hit.
    always_comb begin
        if (src_vld == '0) p_nosrc_quiet_r5: assert (!raw_hit);
    end
endmodule

// File: rtl/hazard_unit_gate.sv
// Unit gate: remembers the unit of the most recent accepted instruction
// and flags a request for another unit while work is still in flight.
// Assumes: any_inflight excludes tags retiring this cycle.
module hazard_unit_gate #(
    parameter int UNIT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [UNIT_W-1:0] iss_unit,
    input  logic              unit_busy,
    input  logic              any_inflight,
    output logic              conflict,
    output logic [UNIT_W-1:0] active_unit
);
    logic [UNIT_W-1:0] unit_q;

    assign active_unit = unit_q;
    assign conflict    = (iss_unit != unit_q) && (unit_busy || any_inflight);

    // Track the unit that owns the in-flight work.
    always_ff @(posedge clk) begin
        if (!rst_n)      unit_q <= '0;
        else if (accept) unit_q <= iss_unit;
    end

    p_switch_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && iss_unit != unit_q) |-> (!unit_busy && !any_inflight));
endmodule

// File: rtl/hazard_tracker.sv
// Issue-stage hazard tracker. Combines the tag table, the read-after-write
// check and the unit gate into one stall / accept decision and hands out
// the issue tag.
// Assumes: results reach the register file only by writeback (no bypass);
// the caller holds a stalled request stable or withdraws it.
module hazard_tracker
    import hazard_pkg::*;
#(
    parameter int NUM_REGS  = 64,
    parameter int NUM_SRC   = 3,
    parameter int TAG_W     = 2,
    parameter int NUM_UNITS = 4,
    localparam int REG_W    = $clog2(NUM_REGS),
    localparam int UNIT_W   = $clog2(NUM_UNITS),
    localparam int NUM_TAGS = 1 << TAG_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     flush,
    input  logic                     iss_valid,
    input  logic [NUM_SRC-1:0]       iss_src_vld,
    input  logic [NUM_SRC*REG_W-1:0] iss_src,
    input  logic                     iss_dst_vld,
    input  logic [REG_W-1:0]         iss_dst,
    input  logic [UNIT_W-1:0]        iss_unit,
    input  logic                     unit_busy,
    input  logic                     wb_valid,
    input  logic [TAG_W-1:0]         wb_tag,
    output logic                     stall,
    output logic [TAG_W-1:0]         iss_tag,
    output logic                     iss_accept
);
    logic [NUM_TAGS-1:0]       busy_eff;
    logic [NUM_TAGS-1:0]       dst_vld;
    logic [NUM_TAGS*REG_W-1:0] dst_flat;
    logic                      next_free;
    logic                      raw_hit;
    logic                      unit_conflict;
    logic [UNIT_W-1:0]         active_unit;
    hz_cause_e                 cause;

    hazard_tag_table #(.TAG_W(TAG_W), .REG_W(REG_W)) u_table (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .alloc(iss_accept), .alloc_dst_vld(iss_dst_vld), .alloc_dst(iss_dst),
        .wb_vld(wb_valid), .wb_tag(wb_tag),
        .next_tag(iss_tag), .next_free(next_free),
        .busy_eff(busy_eff), .dst_vld(dst_vld), .dst_flat(dst_flat)
    );

    hazard_raw_check #(.NUM_SRC(NUM_SRC), .NUM_TAGS(NUM_TAGS), .REG_W(REG_W)) u_raw (
        .src_vld(iss_src_vld), .src_flat(iss_src),
        .busy_eff(busy_eff), .dst_vld(dst_vld), .dst_flat(dst_flat),
        .raw_hit(raw_hit)
    );

    hazard_unit_gate #(.UNIT_W(UNIT_W)) u_gate (
        .clk(clk), .rst_n(rst_n), .accept(iss_accept), .iss_unit(iss_unit),
        .unit_busy(unit_busy), .any_inflight(|busy_eff),
        .conflict(unit_conflict), .active_unit(active_unit)
    );

    // Prioritised reason for holding the request, or permission to go.
    always_comb begin
        if (!iss_valid)         cause = HZ_IDLE;
        else if (flush)         cause = HZ_FLUSH;
        else if (!next_free)    cause = HZ_TAGFULL;
        else if (unit_conflict) cause = HZ_UNIT;
        else if (raw_hit)       cause = HZ_RAW;
        else                    cause = HZ_GO;
    end

    assign iss_accept = (cause == HZ_GO);
    assign stall      = (cause != HZ_GO) && (cause != HZ_IDLE);

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !iss_valid |-> (!stall && !iss_accept));
    p_raw_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
        iss_accept |-> !raw_hit);
    p_tag_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_accept && !flush) |=> (iss_tag == $past(iss_tag) + 1'b1));
    p_flush_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !iss_accept);
    p_unit_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_accept && !flush) |=> (active_unit == $past(iss_unit)));
endmodule

// File: tb/hazard_tracker_test.sv
module hazard_tracker_test;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic       v;
        logic [2:0] sv;
        logic [5:0] s0;
        logic [5:0] s1;
        logic [5:0] s2;
        logic       dv;
        logic [5:0] d;
        logic [1:0] u;
        logic       wv;
        logic [1:0] wt;
        logic       ub;
        logic       fl;
        logic       ea;
        logic [1:0] et;
        logic [3:0] rq;
    } vec_t;

    localparam int NV = 21;
    //                  v  sv     s0 s1  s2 dv d   u  wv wt ub fl ea et rq
    localparam vec_t TBL [NV] = '{
        '{1'b1,3'b000, 0, 0, 0,1'b1, 5,2'd0,1'b0,2'd0,1'b0,1'b0,1'b1,2'd0,4'd1},  // R1 first tag
        '{1'b1,3'b001, 5, 0, 0,1'b1, 6,2'd0,1'b0,2'd0,1'b0,1'b0,1'b0,2'd1,4'd3},  // R3 src0 hit
        '{1'b1,3'b001, 5, 0, 0,1'b1, 6,2'd0,1'b0,2'd0,1'b1,1'b0,1'b0,2'd1,4'd3},  // R3 still held
        '{1'b1,3'b001, 5, 0, 0,1'b1, 6,2'd0,1'b1,2'd0,1'b1,1'b0,1'b1,2'd1,4'd4},  // R4 same-cycle wb
        '{1'b1,3'b000, 6, 0, 0,1'b0, 9,2'd0,1'b0,2'd0,1'b1,1'b0,1'b1,2'd2,4'd5},  // R5 invalid src
        '{1'b1,3'b001, 7, 0, 0,1'b1, 7,2'd0,1'b0,2'd0,1'b1,1'b0,1'b1,2'd3,4'd6},  // R6 overlap
        '{1'b1,3'b100, 0, 0, 9,1'b1,10,2'd0,1'b0,2'd0,1'b1,1'b0,1'b1,2'd0,4'd5},  // R5 no-dst writer
        '{1'b1,3'b000, 0, 0, 0,1'b1,11,2'd0,1'b0,2'd0,1'b0,1'b0,1'b0,2'd1,4'd8},  // R8 full
        '{1'b1,3'b000, 0, 0, 0,1'b1,11,2'd0,1'b1,2'd2,1'b0,1'b0,1'b0,2'd1,4'd8},  // R8 wrong tag wb
        '{1'b1,3'b000, 0, 0, 0,1'b1,11,2'd0,1'b1,2'd1,1'b0,1'b0,1'b1,2'd1,4'd8},  // R8 own tag wb
        '{1'b1,3'b010, 0,11, 0,1'b0, 0,2'd0,1'b0,2'd0,1'b0,1'b0,1'b0,2'd2,4'd3},  // R3 src1 hit
        '{1'b1,3'b000, 0, 0, 0,1'b0, 0,2'd1,1'b0,2'd0,1'b0,1'b0,1'b0,2'd2,4'd7},  // R7 inflight
        '{1'b0,3'b000, 0, 0, 0,1'b0, 0,2'd0,1'b1,2'd0,1'b0,1'b0,1'b0,2'd2,4'd10}, // R10 idle
        '{1'b0,3'b000, 0, 0, 0,1'b0, 0,2'd0,1'b1,2'd3,1'b0,1'b0,1'b0,2'd2,4'd10}, // R10 idle
        '{1'b1,3'b000, 0, 0, 0,1'b0, 0,2'd1,1'b1,2'd1,1'b1,1'b0,1'b0,2'd2,4'd7},  // R7 busy flag
        '{1'b1,3'b000, 0, 0, 0,1'b1,20,2'd1,1'b0,2'd0,1'b0,1'b0,1'b1,2'd2,4'd7},  // R7 switch ok
        '{1'b1,3'b000, 0, 0, 0,1'b0, 0,2'd0,1'b0,2'd0,1'b0,1'b0,1'b0,2'd3,4'd7},  // R7 back blocked
        '{1'b1,3'b000, 0, 0, 0,1'b0, 0,2'd0,1'b0,2'd0,1'b0,1'b1,1'b0,2'd3,4'd9},  // R9 flush
        '{1'b1,3'b001,20, 0, 0,1'b1, 5,2'd0,1'b0,2'd0,1'b0,1'b0,1'b1,2'd0,4'd9},  // R9 cleared
        '{1'b1,3'b010, 0, 5, 0,1'b0, 0,2'd0,1'b0,2'd0,1'b0,1'b0,1'b0,2'd1,4'd3},  // R3 src1 hit
        '{1'b1,3'b010, 0, 5, 0,1'b0, 0,2'd0,1'b1,2'd0,1'b0,1'b0,1'b1,2'd1,4'd4}   // R4 release
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        flush;
    logic        iss_valid;
    logic [2:0]  iss_src_vld;
    logic [17:0] iss_src;
    logic        iss_dst_vld;
    logic [5:0]  iss_dst;
    logic [1:0]  iss_unit;
    logic        unit_busy;
    logic        wb_valid;
    logic [1:0]  wb_tag;
    logic        stall;
    logic [1:0]  iss_tag;
    logic        iss_accept;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hazard_tracker uut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .iss_valid(iss_valid),
        .iss_src_vld(iss_src_vld), .iss_src(iss_src), .iss_dst_vld(iss_dst_vld),
        .iss_dst(iss_dst), .iss_unit(iss_unit), .unit_busy(unit_busy),
        .wb_valid(wb_valid), .wb_tag(wb_tag), .stall(stall), .iss_tag(iss_tag),
        .iss_accept(iss_accept)
    );

    task automatic check(input int act, input int exp, input int rq, input string what);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL R%0d %s: actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic apply(input vec_t t);
        iss_valid   = t.v;
        iss_src_vld = t.sv;
        iss_src     = {t.s2, t.s1, t.s0};
        iss_dst_vld = t.dv;
        iss_dst     = t.d;
        iss_unit    = t.u;
        wb_valid    = t.wv;
        wb_tag      = t.wt;
        unit_busy   = t.ub;
        flush       = t.fl;
    endtask

    // Drive at the falling edge, sample 1 time unit later, then let the rising edge commit.
    task automatic run(input vec_t t);
        @(negedge clk);
        apply(t);
        #1;
        check(int'(iss_accept), int'(t.ea), int'(t.rq), "accept");
        check(int'(iss_tag), int'(t.et), int'(t.rq), "tag");
        check(int'(stall), int'(t.v & ~t.ea), int'(t.rq), "stall");
    endtask

    task automatic do_reset();
        @(negedge clk);
        apply('0);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        vec_t t;
        rst_n = 1'b0;
        apply('0);
        do_reset();
        // R2: reset state
        #1;
        check(int'(iss_tag), 0, 2, "reset tag");
        check(int'(stall), 0, 2, "reset stall");
        check(int'(iss_accept), 0, 2, "reset accept");

        for (int i = 0; i < NV; i++) run(TBL[i]);

        // R2: reset in mid-flight, then any unit is free and tags restart at 0
        do_reset();
        t = '0;
        t.v = 1'b1; t.dv = 1'b1; t.d = 6'd63; t.u = 2'd3;
        t.ea = 1'b1; t.et = 2'd0; t.rq = 4'd2;
        run(t);
        // R3: top register number through source 2
        t = '0;
        t.v = 1'b1; t.sv = 3'b100; t.s2 = 6'd63; t.u = 2'd3;
        t.ea = 1'b0; t.et = 2'd1; t.rq = 4'd3;
        run(t);
        // R4: same-cycle writeback of tag 0 releases it
        t.wv = 1'b1; t.wt = 2'd0; t.ea = 1'b1; t.rq = 4'd4;
        run(t);
        // R1: pointer advanced to 2 after the accept
        @(negedge clk);
        apply('0);
        #1;
        check(int'(iss_tag), 2, 1, "tag after accept");

        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule